// File: doc/BRIEF.md
# Linked Descriptor Queue Manager

This block keeps a set of hardware queues of fixed-size descriptors. A descriptor is named by its byte address, but every queue is stored as a singly linked list of descriptor indices. The lists share one link memory that has one next-index slot per descriptor. Each queue has head, tail and count registers. A small table of descriptor regions converts a pushed address into a global index. On pop, the same table converts the index back into an address.

Software first loads the region entries through the configuration port. Each entry gives a base address, the first link-memory index the region uses, the descriptor size in 16-byte units and the log2 of the descriptor count. Producers then push descriptor addresses into numbered queues, and consumers pop them in arrival order. The count of any queue can be read at any time through a combinational select. An address that matches no region is dropped and raises a sticky error. A pop that arrives in the same cycle as a push is held for one cycle so that the push is applied first.

Top module: `dq_mgr`

## Requirements
- R1: After reset every queue count reads zero, `pop_done` and `push_err` are low, and a pop of any queue reports empty.
- R2: A configuration write makes its region usable only when all four conditions hold: the base address has bits [3:0] equal to zero, the size is at least 2 units (32 bytes), the count log2 is at least 5 and no larger than the link index width, and start plus count does not exceed the link depth. Otherwise the entry is left unusable, and pushes into its range are rejected.
- R3: A push is accepted only when its address lies inside a usable region, at base + k*size for some k below the region count. A pop later returns exactly that address.
- R4: Each queue returns its descriptors in push order. Pushes and pops on other queues have no effect on it.
- R5: `cnt_out` shows the number of descriptors held in queue `cnt_qsel`. It changes in the cycle after the edge that applies a push or a pop.
- R6: A pop of an empty queue gives `pop_done`=1, `pop_empty`=1 and `pop_addr`=0, and the queue count does not change.
- R7: A push that hits no usable region leaves every queue unchanged and sets `push_err`. `push_err` stays set until reset.
- R8: When `push_valid` and `pop_valid` are both high in one cycle, the push is applied in that cycle and the pop is applied in the next cycle, so the pop sees the push. This holds even when both name the same empty queue.
- R9: A pop that is not held shows its result in the cycle after the request. A held pop shows its result two cycles after the request.
- R10: While a held pop is applied, a new push and a new pop may arrive. The push is applied in the same cycle, after the held pop. The new pop is held in turn, and no request is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one region entry |
| cfg_sel | input | RG_W | Region entry number |
| cfg_base | input | ADDR_W | Region base byte address |
| cfg_start | input | IDX_W | First link index of the region |
| cfg_units | input | SZ_W | Descriptor size in 16-byte units |
| cfg_cnt_lg | input | CL_W | Log2 of the descriptor count |
| push_valid | input | 1 | Push request |
| push_qnum | input | QW | Queue to push into |
| push_addr | input | ADDR_W | Descriptor address to push |
| pop_valid | input | 1 | Pop request |
| pop_qnum | input | QW | Queue to pop from |
| pop_done | output | 1 | Pop result valid |
| pop_addr | output | ADDR_W | Popped descriptor address, 0 when empty |
| pop_empty | output | 1 | The pop found its queue empty |
| push_err | output | 1 | Sticky flag for a push that hit no region |
| cnt_qsel | input | QW | Queue whose count is shown |
| cnt_out | output | CNT_W | Descriptor count of the selected queue |

## Verification
A push and a pop can arrive in the same cycle, and both may name the same queue. The bench drives both strobes on one falling edge into an empty queue. It expects no result one cycle later, and two cycles later it expects the pushed address rather than an empty report. A second sequence keeps both strobes high while the held pop runs. This checks that the held pop, the new push and the next held pop each take effect in order, with the counts checked at every step.

// File: rtl/dq_pkg.sv
package dq_pkg;
    // descriptor alignment granule is 2**ALIGN_LG bytes
    localparam int ALIGN_LG   = 4;
    localparam int MIN_UNITS  = 2;
    localparam int MIN_CNT_LG = 5;
    localparam int MAX_RG     = 20;

    typedef enum logic [1:0] {
        PS_NONE = 2'd0,
        PS_LIVE = 2'd1,
        PS_HELD = 2'd2
    } pop_src_e;
endpackage

// File: rtl/dq_link_ram.sv
module dq_link_ram #(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [IDX_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [IDX_W-1:0] rdata
);
    logic [IDX_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dq_region_tbl.sv
module dq_region_tbl
    import dq_pkg::*;
#(
    parameter int NUM_RG     = 4,
    parameter int ADDR_W     = 32,
    parameter int LINK_DEPTH = 256,
    parameter int SZ_W       = 4,
    parameter int IDX_W      = $clog2(LINK_DEPTH),
    parameter int CL_W       = $clog2(IDX_W + 1),
    parameter int RG_W       = $clog2(NUM_RG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RG_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_start,
    input  logic [SZ_W-1:0]   cfg_units,
    input  logic [CL_W-1:0]   cfg_cnt_lg,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [NUM_RG-1:0] rg_vld
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  start;
        logic [SZ_W-1:0]   units;
        logic [CL_W-1:0]   clg;
    } rg_t;

    rg_t [NUM_RG-1:0] tbl_d, tbl_q;

    logic        cfg_ok;
    logic [31:0] cfg_span_w;
    logic [31:0] cfg_end_w;

    always_comb begin
        cfg_span_w = 32'd1 << cfg_cnt_lg;
        cfg_end_w  = 32'(cfg_start) + cfg_span_w;
        cfg_ok     = (cfg_base[ALIGN_LG-1:0] == '0)
                  && (32'(cfg_units) >= 32'(MIN_UNITS))
                  && (32'(cfg_cnt_lg) >= 32'(MIN_CNT_LG))
                  && (32'(cfg_cnt_lg) <= 32'(IDX_W))
                  && (cfg_end_w <= 32'(LINK_DEPTH));
        tbl_d = tbl_q;
        if (cfg_we && (32'(cfg_sel) < 32'(NUM_RG))) begin
            tbl_d[cfg_sel].vld   = cfg_ok;
            tbl_d[cfg_sel].base  = cfg_base;
            tbl_d[cfg_sel].start = cfg_start;
            tbl_d[cfg_sel].units = cfg_units;
            tbl_d[cfg_sel].clg   = cfg_cnt_lg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    logic [NUM_RG-1:0] hit_a;
    logic [NUM_RG-1:0] own_a;
    logic [IDX_W-1:0]  idx_a  [NUM_RG];
    logic [ADDR_W-1:0] addr_a [NUM_RG];

    for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] step;
        logic [ADDR_W-1:0] span;
        logic [IDX_W:0]    rel;
        logic [IDX_W:0]    cnt;

        assign rg_vld[g] = tbl_q[g].vld;
        // address to index
        assign off  = lk_addr - tbl_q[g].base;
        assign step = ADDR_W'(tbl_q[g].units) << ALIGN_LG;
        assign span = step << tbl_q[g].clg;
        assign hit_a[g] = tbl_q[g].vld
                       && (lk_addr >= tbl_q[g].base)
                       && (off < span)
                       && ((off % step) == '0);
        assign idx_a[g] = tbl_q[g].start + IDX_W'(off / step);
        // index to address
        assign rel = {1'b0, rb_idx} - {1'b0, tbl_q[g].start};
        assign cnt = (IDX_W+1)'(1) << tbl_q[g].clg;
        assign own_a[g] = tbl_q[g].vld
                       && (rb_idx >= tbl_q[g].start)
                       && (rel < cnt);
        assign addr_a[g] = tbl_q[g].base
                         + ((ADDR_W'(rel) * ADDR_W'(tbl_q[g].units)) << ALIGN_LG);
    end

    // lowest-numbered matching region wins
    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = '0;
        rb_addr = '0;
        for (int i = NUM_RG - 1; i >= 0; i--) begin
            if (hit_a[i]) begin
                lk_hit = 1'b1;
                lk_idx = idx_a[i];
            end
            if (own_a[i]) rb_addr = addr_a[i];
        end
    end
endmodule

// File: rtl/dq_mgr.sv
module dq_mgr
    import dq_pkg::*;
#(
    parameter int NUM_Q      = 8,
    parameter int NUM_RG     = 4,
    parameter int LINK_DEPTH = 256,
    parameter int ADDR_W     = 32,
    parameter int SZ_W       = 4,
    parameter int QW         = $clog2(NUM_Q),
    parameter int RG_W       = $clog2(NUM_RG),
    parameter int IDX_W      = $clog2(LINK_DEPTH),
    parameter int CNT_W      = IDX_W + 1,
    parameter int CL_W       = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RG_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_start,
    input  logic [SZ_W-1:0]   cfg_units,
    input  logic [CL_W-1:0]   cfg_cnt_lg,
    input  logic              push_valid,
    input  logic [QW-1:0]     push_qnum,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_valid,
    input  logic [QW-1:0]     pop_qnum,
    output logic              pop_done,
    output logic [ADDR_W-1:0] pop_addr,
    output logic              pop_empty,
    output logic              push_err,
    input  logic [QW-1:0]     cnt_qsel,
    output logic [CNT_W-1:0]  cnt_out
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } qrec_t;

    typedef struct packed {
        qrec_t [NUM_Q-1:0] q;
        logic              hold_v;
        logic [QW-1:0]     hold_q;
        logic              rsp_v;
        logic [ADDR_W-1:0] rsp_addr;
        logic              rsp_empty;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  rb_idx;
    logic [ADDR_W-1:0] rb_addr;
    logic [NUM_RG-1:0] rg_vld;
    logic              lr_we;
    logic [IDX_W-1:0]  lr_waddr, lr_wdata, lr_rdata;
    logic              hold_v;
    pop_src_e          pop_src;
    logic [QW-1:0]     pop_sel;

    dq_region_tbl #(
        .NUM_RG(NUM_RG), .ADDR_W(ADDR_W), .LINK_DEPTH(LINK_DEPTH),
        .SZ_W(SZ_W), .IDX_W(IDX_W), .CL_W(CL_W), .RG_W(RG_W)
    ) u_rtbl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_start(cfg_start), .cfg_units(cfg_units), .cfg_cnt_lg(cfg_cnt_lg),
        .lk_addr(push_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .rb_idx(rb_idx), .rb_addr(rb_addr), .rg_vld(rg_vld)
    );

    dq_link_ram #(.DEPTH(LINK_DEPTH), .IDX_W(IDX_W)) u_link (
        .clk(clk), .we(lr_we), .waddr(lr_waddr), .wdata(lr_wdata),
        .raddr(rb_idx), .rdata(lr_rdata)
    );

    assign hold_v = st_q.hold_v;

    // which pop (if any) is applied this cycle
    always_comb begin
        if (st_q.hold_v) begin
            pop_src = PS_HELD;
            pop_sel = st_q.hold_q;
        end else if (pop_valid && !push_valid) begin
            pop_src = PS_LIVE;
            pop_sel = pop_qnum;
        end else begin
            pop_src = PS_NONE;
            pop_sel = pop_qnum;
        end
        rb_idx = st_q.q[pop_sel].head;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_v     = 1'b0;
        st_d.rsp_addr  = '0;
        st_d.rsp_empty = 1'b0;
        lr_we          = 1'b0;
        lr_waddr       = '0;
        lr_wdata       = '0;

        // a live pop is parked when a push or an older pop owns this cycle
        st_d.hold_v = pop_valid && (push_valid || st_q.hold_v);
        st_d.hold_q = pop_qnum;

        // pop first: it is always older than a push of the same cycle
        if (pop_src != PS_NONE) begin
            st_d.rsp_v = 1'b1;
            if (st_q.q[pop_sel].cnt == '0) begin
                st_d.rsp_empty = 1'b1;
            end else begin
                st_d.rsp_addr        = rb_addr;
                st_d.q[pop_sel].head = lr_rdata;
                st_d.q[pop_sel].cnt  = st_q.q[pop_sel].cnt - 1'b1;
            end
        end

        // push applies to the post-pop queue state
        if (push_valid) begin
            if (lk_hit) begin
                if (st_d.q[push_qnum].cnt == '0) begin
                    st_d.q[push_qnum].head = lk_idx;
                end else begin
                    lr_we    = 1'b1;
                    lr_waddr = st_d.q[push_qnum].tail;
                    lr_wdata = lk_idx;
                end
                st_d.q[push_qnum].tail = lk_idx;
                st_d.q[push_qnum].cnt  = st_d.q[push_qnum].cnt + 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_done  = st_q.rsp_v;
    assign pop_addr  = st_q.rsp_addr;
    assign pop_empty = st_q.rsp_empty;
    assign push_err  = st_q.err;
    assign cnt_out   = st_q.q[cnt_qsel].cnt;
endmodule

// File: rtl/dq_mgr_chk.sv
module dq_mgr_chk #(
    parameter int QW     = 3,
    parameter int CNT_W  = 9,
    parameter int ADDR_W = 32,
    parameter int NUM_RG = 4,
    parameter int RG_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [RG_W-1:0]   cfg_sel,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              push_valid,
    input logic              pop_valid,
    input logic              pop_done,
    input logic [ADDR_W-1:0] pop_addr,
    input logic              pop_empty,
    input logic              push_err,
    input logic [QW-1:0]     cnt_qsel,
    input logic [CNT_W-1:0]  cnt_out,
    input logic              hold_v,
    input logic [NUM_RG-1:0] rg_vld
);
    // R9
    live_pop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !push_valid && !hold_v) |=> pop_done);

    // R8
    held_pop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && push_valid && !hold_v) |=> (!pop_done ##1 pop_done));

    // R6
    empty_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done && pop_empty) |-> (pop_addr == '0));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(push_err));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_qsel == $past(cnt_qsel)) |->
            ((cnt_out == $past(cnt_out))
          || (cnt_out == $past(cnt_out) + 1'b1)
          || (cnt_out + 1'b1 == $past(cnt_out))));

    // R2
    misaligned_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_base[3:0] != 4'd0)) |=> !rg_vld[$past(cfg_sel)]);
endmodule

bind dq_mgr dq_mgr_chk #(
    .QW(QW), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_RG(NUM_RG), .RG_W(RG_W)
) u_chk (.*);

// File: tb/dq_mgr_test.sv
module dq_mgr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [7:0]  cfg_start = '0;
    logic [3:0]  cfg_units = '0;
    logic [3:0]  cfg_cnt_lg = '0;
    logic        push_valid = 1'b0;
    logic [2:0]  push_qnum = '0;
    logic [31:0] push_addr = '0;
    logic        pop_valid = 1'b0;
    logic [2:0]  pop_qnum = '0;
    logic        pop_done;
    logic [31:0] pop_addr;
    logic        pop_empty;
    logic        push_err;
    logic [2:0]  cnt_qsel = '0;
    logic [8:0]  cnt_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dq_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_start(cfg_start), .cfg_units(cfg_units), .cfg_cnt_lg(cfg_cnt_lg),
        .push_valid(push_valid), .push_qnum(push_qnum), .push_addr(push_addr),
        .pop_valid(pop_valid), .pop_qnum(pop_qnum),
        .pop_done(pop_done), .pop_addr(pop_addr), .pop_empty(pop_empty),
        .push_err(push_err), .cnt_qsel(cnt_qsel), .cnt_out(cnt_out)
    );

    typedef struct packed {
        logic        is_pop;
        logic [2:0]  q;
        logic [31:0] addr;      // pushed address, or expected popped address
        logic        exp_empty;
        logic [8:0]  exp_cnt;   // count of q after the operation
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 32'h0000_1000, 1'b0, 9'd1},
        '{1'b0, 3'd0, 32'h0000_1020, 1'b0, 9'd2},
        '{1'b0, 3'd1, 32'h0000_8030, 1'b0, 9'd1},
        '{1'b1, 3'd0, 32'h0000_1000, 1'b0, 9'd1},
        '{1'b0, 3'd0, 32'h0000_13E0, 1'b0, 9'd2},
        '{1'b1, 3'd1, 32'h0000_8030, 1'b0, 9'd0},
        '{1'b1, 3'd1, 32'h0000_0000, 1'b1, 9'd0},
        '{1'b1, 3'd0, 32'h0000_1020, 1'b0, 9'd1},
        '{1'b1, 3'd0, 32'h0000_13E0, 1'b0, 9'd0},
        '{1'b1, 3'd0, 32'h0000_0000, 1'b1, 9'd0},
        '{1'b0, 3'd2, 32'h0000_8BD0, 1'b0, 9'd1},
        '{1'b1, 3'd2, 32'h0000_8BD0, 1'b0, 9'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] base,
                       input logic [7:0] start, input logic [3:0] units,
                       input logic [3:0] clg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_base = base;
        cfg_start = start; cfg_units = units; cfg_cnt_lg = clg;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one push, result visible at the following falling edge
    task automatic push1(input logic [2:0] q, input logic [31:0] a);
        @(negedge clk);
        push_valid = 1'b1; push_qnum = q; push_addr = a; cnt_qsel = q;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop1(input logic [2:0] q);
        @(negedge clk);
        pop_valid = 1'b1; pop_qnum = q; cnt_qsel = q;
        @(negedge clk);
        pop_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pop_done", 32'(pop_done), 32'd0);
        chk("R1 push_err", 32'(push_err), 32'd0);
        for (int i = 0; i < 8; i++) begin
            cnt_qsel = 3'(i);
            #1;
            chk("R1 count", 32'(cnt_out), 32'd0);
        end
        pop1(3'd7);
        chk("R1 pop empty", 32'(pop_empty), 32'd1);

        // region 0: 32 x 32 B at 0x1000, idx 0..31
        cfg(2'd0, 32'h0000_1000, 8'd0, 4'd2, 4'd5);
        // region 1: 64 x 48 B at 0x8000, idx 32..95
        cfg(2'd1, 32'h0000_8000, 8'd32, 4'd3, 4'd6);

        // R3 R4 R5 R6 table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].is_pop) begin
                pop1(VEC[v].q);
                chk("R6 pop_done", 32'(pop_done), 32'd1);
                chk("R6 pop_empty", 32'(pop_empty), 32'(VEC[v].exp_empty));
                chk("R4 pop_addr", pop_addr, VEC[v].addr);
            end else begin
                push1(VEC[v].q, VEC[v].addr);
            end
            chk("R5 count", 32'(cnt_out), 32'(VEC[v].exp_cnt));
        end
        chk("R7 no error yet", 32'(push_err), 32'd0);

        // R3 R7 address between descriptors is rejected
        push1(3'd5, 32'h0000_1010);
        chk("R7 err set", 32'(push_err), 32'd1);
        chk("R3 off-grid dropped", 32'(cnt_out), 32'd0);
        // R3 one past the end of region 0
        push1(3'd5, 32'h0000_1400);
        chk("R3 past end dropped", 32'(cnt_out), 32'd0);

        // R2 rejected configurations
        cfg(2'd2, 32'h0002_0008, 8'd100, 4'd2, 4'd5);
        push1(3'd5, 32'h0002_0008);
        chk("R2 misaligned base", 32'(cnt_out), 32'd0);
        cfg(2'd2, 32'h0002_0000, 8'd100, 4'd1, 4'd5);
        push1(3'd5, 32'h0002_0000);
        chk("R2 size too small", 32'(cnt_out), 32'd0);
        cfg(2'd2, 32'h0002_0000, 8'd100, 4'd2, 4'd4);
        push1(3'd5, 32'h0002_0000);
        chk("R2 count too small", 32'(cnt_out), 32'd0);
        cfg(2'd2, 32'h0002_0000, 8'd240, 4'd2, 4'd5);
        push1(3'd5, 32'h0002_0000);
        chk("R2 beyond link depth", 32'(cnt_out), 32'd0);
        // R2 accepted
        cfg(2'd2, 32'h0002_0000, 8'd100, 4'd2, 4'd5);
        push1(3'd5, 32'h0002_0020);
        chk("R2 valid region count", 32'(cnt_out), 32'd1);
        chk("R7 still set", 32'(push_err), 32'd1);
        pop1(3'd5);
        chk("R3 round trip", pop_addr, 32'h0002_0020);

        // R8 collision on an empty queue
        @(negedge clk);
        push_valid = 1'b1; push_qnum = 3'd3; push_addr = 32'h0000_1040;
        pop_valid = 1'b1; pop_qnum = 3'd3; cnt_qsel = 3'd3;
        @(negedge clk);
        push_valid = 1'b0; pop_valid = 1'b0;
        chk("R8 no result yet", 32'(pop_done), 32'd0);
        chk("R8 push applied", 32'(cnt_out), 32'd1);
        @(negedge clk);
        chk("R9 held result", 32'(pop_done), 32'd1);
        chk("R8 sees push", pop_addr, 32'h0000_1040);
        chk("R8 count after", 32'(cnt_out), 32'd0);

        // R10 held pop overlapped with a new push and pop
        @(negedge clk);
        push_valid = 1'b1; push_qnum = 3'd4; push_addr = 32'h0000_1080;
        pop_valid = 1'b1; pop_qnum = 3'd4; cnt_qsel = 3'd4;
        @(negedge clk);
        chk("R10 first hold", 32'(pop_done), 32'd0);
        push_addr = 32'h0000_10A0;
        @(negedge clk);
        push_valid = 1'b0; pop_valid = 1'b0;
        chk("R10 first result", pop_addr, 32'h0000_1080);
        chk("R10 count mid", 32'(cnt_out), 32'd1);
        @(negedge clk);
        chk("R10 second done", 32'(pop_done), 32'd1);
        chk("R10 second result", pop_addr, 32'h0000_10A0);
        chk("R10 drained", 32'(cnt_out), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule